// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned word by another over several clock cycles with the shift-and-subtract method. A single-cycle start request captures both operands. The unit then decides one quotient bit per cycle, and a one-cycle done strobe marks the cycle in which the quotient and remainder are valid. Those results stay on the outputs until the next division finishes.

Inside, a double-width partial remainder is compared with a double-width divisor copy that begins in the upper half and moves one place toward the least significant end on each step. When the trial difference is non-negative, it replaces the partial remainder and a 1 enters the quotient from the right. Otherwise the partial remainder is kept as it was and a 0 enters. There is one more step than the operand has bits. A zero divisor needs no special case, because every trial then fits.

Top module: `restoring_divider`

## Requirements
- R1: During and right after reset, `busy` and `done` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` sampled high while `busy` is 0 captures `dividend` and `divisor`. `busy` is 1 from the next cycle for exactly W+1 cycles (33 at the default width).
- R3: `done` is high for exactly one cycle. It rises on the (W+2)th rising edge, counting the edge that accepted `start` as the first, and `busy` is 0 in that cycle.
- R4: When `done` is high, `quotient` equals the floor of `dividend / divisor` for the captured operands when `divisor` is non-zero.
- R5: When `done` is high, `remainder` equals `dividend mod divisor` for the captured operands when `divisor` is non-zero.
- R6: A zero divisor gives a `quotient` with every bit set and a `remainder` equal to the dividend.
- R7: A `start` sampled while `busy` is 1 is ignored: no extra `done` follows, and the running division returns the results of its own operands.
- R8: `quotient` and `remainder` keep their values in every cycle in which `done` is 0.
- R9: A `start` in the same cycle as `done` is accepted. The next division begins at once without an idle cycle.
- R10: A dividend smaller than a non-zero divisor gives a quotient of 0 and a remainder equal to the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division, one cycle |
| dividend | input | W | Unsigned numerator, captured with start |
| divisor | input | W | Unsigned denominator, captured with start |
| busy | output | 1 | High while quotient bits are being formed |
| done | output | 1 | One-cycle strobe: results valid |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |

## Verification
Two pairs of events can fall in the same cycle here. The completion strobe can coincide with the acceptance of a new start, and a start request can arrive while an earlier division is still running. The stimulus issues every division in the first cycle after `busy` drops, which is always the done cycle, so each completion overlaps the next capture. A scoreboard judges this through the result values and through the latency of each strobe. A start is also injected mid-run with different operands. It passes if that run returns its own operands' results and no unmatched strobe appears.

// File: rtl/div_pkg.sv
package div_pkg;

   typedef enum logic {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_e;

   // trial subtractor variants
   localparam int unsigned TRIAL_BORROW  = 0;
   localparam int unsigned TRIAL_COMPARE = 1;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
   import div_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic last,
   output logic busy
);
   localparam int unsigned STEPS = W + 1;
   localparam int unsigned CW    = $clog2(STEPS + 1);

   div_state_e      state_q;
   logic [CW-1:0]   cnt_q;

   assign busy = (state_q == DIV_RUN);
   assign load = (state_q == DIV_IDLE) && start;
   assign step = busy;
   assign last = busy && (cnt_q == CW'(STEPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DIV_IDLE;
         cnt_q   <= '0;
      end else if (load) begin
         state_q <= DIV_RUN;
         cnt_q   <= '0;
      end else if (last) begin
         state_q <= DIV_IDLE;
         cnt_q   <= '0;
      end else if (step) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/div_trial.sv
module div_trial
   import div_pkg::*;
#(
   parameter int unsigned W    = 32,
   parameter int unsigned IMPL = TRIAL_BORROW
) (
   input  logic [2*W-1:0] rem,
   input  logic [2*W-1:0] dsr,
   output logic [2*W-1:0] diff,
   output logic           fits
);
   localparam int unsigned DW = 2 * W;

   generate
      if (IMPL == TRIAL_BORROW) begin : g_borrow
         logic [DW:0] wide;
         assign wide = {1'b0, rem} - {1'b0, dsr};
         assign diff = wide[DW-1:0];
         assign fits = ~wide[DW];
      end else begin : g_compare
         assign diff = rem - dsr;
         assign fits = (rem >= dsr);
      end
   endgenerate
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
   parameter int unsigned W    = 32,
   parameter int unsigned IMPL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] quo_nxt,
   output logic [W-1:0] rem_nxt
);
   localparam int unsigned DW = 2 * W;

   logic [DW-1:0] rem_q, dsr_q, diff;
   logic [W-1:0]  quo_q;
   logic          fits;

   div_trial #(.W(W), .IMPL(IMPL)) u_trial (
      .rem  (rem_q),
      .dsr  (dsr_q),
      .diff (diff),
      .fits (fits)
   );

   // values after the current step, taken by the result stage on the last one
   assign quo_nxt = {quo_q[W-2:0], fits};
   assign rem_nxt = fits ? diff[W-1:0] : rem_q[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         dsr_q <= '0;
         quo_q <= '0;
      end else if (load) begin
         rem_q <= {{W{1'b0}}, dividend};
         dsr_q <= {divisor, {W{1'b0}}};
         quo_q <= '0;
      end else if (step) begin
         if (fits) rem_q <= diff;
         dsr_q <= {1'b0, dsr_q[DW-1:1]};
         quo_q <= quo_nxt;
      end
   end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
   import div_pkg::*;
#(
   parameter int unsigned W    = 32,
   parameter int unsigned IMPL = TRIAL_BORROW
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quotient,
   output logic [W-1:0] remainder
);
   generate
      if (W < 2) begin : g_bad_width
         $error("restoring_divider: W must be at least 2");
      end
      if (IMPL > TRIAL_COMPARE) begin : g_bad_impl
         $error("restoring_divider: IMPL selects no trial variant");
      end
   endgenerate

   logic         load, step, last;
   logic [W-1:0] quo_nxt, rem_nxt;
   logic         done_q;
   logic [W-1:0] quo_out_q, rem_out_q;

   div_ctrl #(.W(W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .last  (last),
      .busy  (busy)
   );

   div_datapath #(.W(W), .IMPL(IMPL)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .dividend (dividend),
      .divisor  (divisor),
      .quo_nxt  (quo_nxt),
      .rem_nxt  (rem_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q    <= 1'b0;
         quo_out_q <= '0;
         rem_out_q <= '0;
      end else begin
         done_q <= last;
         if (last) begin
            quo_out_q <= quo_nxt;
            rem_out_q <= rem_nxt;
         end
      end
   end

   assign done      = done_q;
   assign quotient  = quo_out_q;
   assign remainder = rem_out_q;
endmodule

// File: rtl/div_chk.sv
module div_chk #(
   parameter int unsigned W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic [W-1:0] quotient,
   input logic [W-1:0] remainder
);
   localparam int unsigned LW = $clog2(W + 3) + 1;

   logic [LW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_len <= '0;
      else if (start && !busy) run_len <= '0;
      else if (busy)           run_len <= run_len + 1'b1;
   end

   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R2
   run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == LW'(W + 1)));

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8
   hold_quo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(quotient));

   // R8
   hold_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(remainder));
endmodule

bind restoring_divider div_chk #(.W(W)) u_div_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .quotient  (quotient),
   .remainder (remainder)
);

// File: tb/tb_restoring_divider.sv
module tb_restoring_divider;
   localparam int W = 32;

   typedef struct {
      logic [W-1:0] dvd;
      logic [W-1:0] dvs;
      logic [W-1:0] q;
      logic [W-1:0] r;
      int           due;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic         busy, done;
   logic [W-1:0] quotient, remainder;

   int   total = 0;
   int   bad = 0;
   int   cyc = 0;
   int   finished = 0;
   logic prev_done = 1'b0;
   exp_t sb[$];

   restoring_divider #(.W(W)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .dividend  (dividend),
      .divisor   (divisor),
      .busy      (busy),
      .done      (done),
      .quotient  (quotient),
      .remainder (remainder)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: waits until idle (the done cycle after the first run), then issues one start
   task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      exp_t e;
      @(negedge clk);
      while (busy) @(negedge clk);
      e.dvd = a;
      e.dvs = b;
      e.q   = (b == 0) ? '1 : a / b;
      e.r   = (b == 0) ? a  : a % b;
      e.due = cyc + 34;
      e.tag = tag;
      sb.push_back(e);
      dividend = a;
      divisor  = b;
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (done && prev_done) check("R3 done width", 1, 0);
            if (done) begin
               if (sb.size() == 0) begin
                  check("R7 unmatched done", 1, 0);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  check({e.tag, " quotient"}, quotient, e.q);
                  check({e.tag, " remainder"}, remainder, e.r);
                  check("R3 R9 latency", W'(cyc), W'(e.due));
                  check("R3 busy low at done", W'(busy), 0);
                  finished++;
               end
            end
            prev_done = done;
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [W-1:0] held_q, held_r;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy", W'(busy), 0);
      check("R1 done", W'(done), 0);
      check("R1 quotient", quotient, 0);
      check("R1 remainder", remainder, 0);
      rst_n = 1'b1;
      @(negedge clk);

      issue(32'd100, 32'd7, "R4 R5");
      check("R2 busy after start", W'(busy), 1);
      issue(32'hFFFF_FFFF, 32'd1, "R4 R5 R9");
      issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 R5 R9");
      issue(32'h8000_0000, 32'd3, "R4 R5");
      issue(32'd12345, 32'd0, "R6");
      issue(32'd0, 32'd0, "R6 zero");
      issue(32'd5, 32'd9, "R10");
      issue(32'd0, 32'd17, "R10 zero dividend");
      issue(32'hDEAD_BEEF, 32'h0001_0000, "R4 R5");
      issue(32'h7FFF_FFFF, 32'h8000_0000, "R10");

      // R7: start mid-run with other operands must be ignored
      issue(32'd1000, 32'd10, "R7");
      repeat (5) @(negedge clk);
      dividend = 32'd77;
      divisor  = 32'd2;
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
      while (sb.size() != 0) @(negedge clk);

      // R8: results hold after done until a new run completes
      held_q = quotient;
      held_r = remainder;
      repeat (40) @(negedge clk);
      check("R7 no extra done", W'(finished), 11);
      check("R8 quotient held", quotient, held_q);
      check("R8 remainder held", remainder, held_r);
      check("R2 idle after run", W'(busy), 0);

      issue(32'd31, 32'd5, "R4 R5");
      while (sb.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule